// File: doc/BRIEF.md
# Serial Receiver with Queued Per-Byte Status

This block is the receive half of an asynchronous serial channel. A programmable divider produces a tick at sixteen times the bit rate. A state machine uses this tick to find a start bit, confirm it at mid-bit, and then collect eight data bits (least significant first), an optional extra bit and a stop bit. Each byte it receives goes into a four-deep queue. Alongside the queue sits a second four-deep queue of 4-bit status words, and the two queues always move together. The receiver does not store an overrun in the status queue. It keeps overrun in its own sticky latch.

The CPU side reads the oldest byte and its status from `rd_data` and `rd_stat`, then pulses `pop`. Three conditions force the receiver into a cleared state: asynchronous reset, the `io_stop` input, and a high `dcd` while `dcd_auto` is set. A forced clear empties both queues, clears the overrun latch and clears the receive and transmit enable bits.

Top module: `uart_rx_errq`

## Requirements
- R1: After reset, `rd_valid`, `ovr`, `rx_on` and `tx_on` are all 0. A pulse of `en_wr` loads `rx_on` from `en_wdata[0]` and `tx_on` from `en_wdata[1]`.
- R2: One bit lasts 16*(`baud_div`+1) clocks. A frame is a low start bit, eight data bits sent LSB first, an extra bit when `mp_mode` or `par_en` is set, and a stop bit. Once the frame completes, the byte appears on `rd_data` with `rd_valid` high.
- R3: The start bit is sampled again at its midpoint. If the line is high at that point, the receiver returns to idle and stores no byte.
- R4: `rd_stat[0]` is the parity error flag. It can only be set when `par_en`=1 and `mp_mode`=0. It is set when the XOR of the eight data bits and the extra bit differs from `par_odd`.
- R5: `rd_stat[1]` is the framing error flag and is set when the stop bit samples low. `rd_stat[2]` is the break flag and is set when the stop bit samples low and all data bits are zero.
- R6: `rd_stat[3]` holds the extra bit when `mp_mode`=1 and is 0 otherwise. While `mp_mode`=1, no parity is checked.
- R7: The queue holds up to four bytes. Bytes leave in arrival order, each with its own status. `pop` removes the oldest entry. A `pop` while the queue is empty is ignored.
- R8: A byte that completes while four entries are held is dropped, and `ovr` sets. The stored entries stay unchanged. `ovr_clr` clears the latch.
- R9: While `io_stop` is high, the next clock edge empties the queue, clears `ovr`, `rx_on` and `tx_on`, and returns the receiver to idle. `en_wr` has no effect while the clear is forced.
- R10: While `dcd_auto`=1 and `dcd`=1, the same forced clear is applied continuously.
- R11: While `dcd_auto`=0, `dcd` has no effect on the queue, the latch or the enable bits.
- R12: While `rx_on`=0, no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idles high |
| baud_div | input | DIV_W | Tick period minus one, in clocks |
| par_en | input | 1 | Extra bit is a parity bit |
| par_odd | input | 1 | Odd parity when set |
| mp_mode | input | 1 | Extra bit is an address/data marker |
| en_wr | input | 1 | Load enable bits |
| en_wdata | input | 2 | Bit 0 receive enable, bit 1 transmit enable |
| io_stop | input | 1 | Force cleared state |
| dcd_auto | input | 1 | Let `dcd` force the cleared state |
| dcd | input | 1 | Carrier detect, high means no carrier |
| pop | input | 1 | Remove oldest entry |
| ovr_clr | input | 1 | Clear overrun latch |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | DW | Oldest byte |
| rd_stat | output | 4 | Oldest status: {mp, break, framing, parity} |
| ovr | output | 1 | Overrun latch |
| rx_on | output | 1 | Receive enable |
| tx_on | output | 1 | Transmit enable |

## Verification
The bench sweeps all 256 data values and rotates the frame format and the stop level on each one. A design that misaligns the data shift, or pairs a status word with the wrong byte, fails there at once. It also sends short low glitches, because a receiver that commits on the falling edge alone would queue phantom bytes. Five back-to-back frames test the full-queue case: an overwrite of the last entry, or a missing overrun flag, shows up as wrong bytes or as `ovr` low. The bench forces clears with each source and then checks that no stale status reaches the next byte. It also checks that `dcd` without `dcd_auto` leaves the queue intact.

// File: rtl/uart_rx_errq.sv
module uart_rx_errq #(
  parameter int DIV_W = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             mp_mode,
  input  logic             en_wr,
  input  logic [1:0]       en_wdata,
  input  logic             io_stop,
  input  logic             dcd_auto,
  input  logic             dcd,
  input  logic             pop,
  input  logic             ovr_clr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [3:0]       rd_stat,
  output logic             ovr,
  output logic             rx_on,
  output logic             tx_on
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [2:0] {IDLE, START, DATA, EXTRA, STOP} st_t;

  st_t              st;
  logic [3:0]       s;
  logic [BW-1:0]    bitn;
  logic [DW-1:0]    sh;
  logic             xb;
  logic [DIV_W-1:0] cnt;
  logic             rxd_m, rxd_s;
  logic [DW-1:0]    mem_d [DEPTH];
  logic [3:0]       mem_s [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    count;

  wire force_clr = io_stop | (dcd_auto & dcd);
  wire tick      = rx_on && (cnt == '0);
  wire mid       = tick && (s == 4'd15);
  wire done      = mid && (st == STOP);
  wire full      = (count == CW'(DEPTH));
  wire wr        = done && !full && !force_clr;
  wire rd        = pop && (count != '0) && !force_clr;

  wire       pe_n  = par_en && !mp_mode && ((^sh ^ xb) != par_odd);
  wire       fe_n  = !rxd_s;
  wire       brk_n = !rxd_s && (sh == '0);
  wire       mp_n  = mp_mode && xb;
  wire [3:0] stat_n = {mp_n, brk_n, fe_n, pe_n};

  assign rd_valid = (count != '0);
  assign rd_data  = mem_d[rp];
  assign rd_stat  = rd_valid ? mem_s[rp] : 4'b0;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_on <= 1'b0;
      tx_on <= 1'b0;
      ovr   <= 1'b0;
      cnt   <= '0;
    end else if (force_clr) begin
      rx_on <= 1'b0;
      tx_on <= 1'b0;
      ovr   <= 1'b0;
      cnt   <= '0;
    end else begin
      if (en_wr) begin
        rx_on <= en_wdata[0];
        tx_on <= en_wdata[1];
      end
      if (done && full)  ovr <= 1'b1;
      else if (ovr_clr)  ovr <= 1'b0;
      if (!rx_on)        cnt <= '0;
      else if (tick)     cnt <= baud_div;
      else               cnt <= cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= IDLE;
      s    <= '0;
      bitn <= '0;
      sh   <= '0;
      xb   <= 1'b0;
    end else if (force_clr || !rx_on) begin
      st <= IDLE;
      s  <= '0;
    end else if (tick) begin
      s <= s + 1'b1;
      case (st)
        IDLE:
          if (!rxd_s) begin
            st <= START;
            s  <= '0;
          end
        START:
          if (s == 4'd7) begin
            s <= '0;
            bitn <= '0;
            st <= rxd_s ? IDLE : DATA;
          end
        DATA:
          if (mid) begin
            sh <= {rxd_s, sh[DW-1:1]};
            if (bitn == BW'(DW - 1)) st <= (mp_mode || par_en) ? EXTRA : STOP;
            else bitn <= bitn + 1'b1;
          end
        EXTRA:
          if (mid) begin
            xb <= rxd_s;
            st <= STOP;
          end
        default:
          if (mid) st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (force_clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr) wp <= nxt(wp);
      if (rd) rp <= nxt(rp);
      count <= count + CW'(wr) - CW'(rd);
    end

  always_ff @(posedge clk)
    if (wr) begin
      mem_d[wp] <= sh;
      mem_s[wp] <= stat_n;
    end
endmodule

module uart_rx_errq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_stop,
  input logic       dcd_auto,
  input logic       dcd,
  input logic       pop,
  input logic       rd_valid,
  input logic [3:0] rd_stat,
  input logic       ovr,
  input logic       rx_on,
  input logic       tx_on
);
  // R9
  forced_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stop || (dcd_auto && dcd)) |=> (!rd_valid && !ovr && !rx_on && !tx_on));
  // R8
  ovr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rd_valid));
  // R12
  no_rx_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !rd_valid) |=> !rd_valid);
  // R5
  break_has_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_stat[2]) |-> rd_stat[1]);
  // R7
  entry_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !pop && !io_stop && !(dcd_auto && dcd)) |=> rd_valid);
endmodule

bind uart_rx_errq uart_rx_errq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_stop(io_stop), .dcd_auto(dcd_auto), .dcd(dcd),
  .pop(pop), .rd_valid(rd_valid), .rd_stat(rd_stat), .ovr(ovr),
  .rx_on(rx_on), .tx_on(tx_on)
);

// File: tb/tb_uart_rx_errq.sv
module tb_uart_rx_errq;
  logic clk = 0, rst_n = 0, rxd = 1;
  logic [7:0] baud_div = 0;
  logic par_en = 0, par_odd = 0, mp_mode = 0, en_wr = 0;
  logic [1:0] en_wdata = 0;
  logic io_stop = 0, dcd_auto = 0, dcd = 0, pop = 0, ovr_clr = 0;
  logic rd_valid, ovr, rx_on, tx_on;
  logic [7:0] rd_data;
  logic [3:0] rd_stat;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  uart_rx_errq dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit use_x, input bit x, input bit stp);
    int bt = 16 * (int'(baud_div) + 1);
    hold(0, bt);
    for (int i = 0; i < 8; i++) hold(d[i], bt);
    if (use_x) hold(x, bt);
    hold(stp, bt);
    hold(1, bt);
  endtask

  task automatic do_pop();
    pop = 1; @(negedge clk); pop = 0;
  endtask

  task automatic wr_en(input logic [1:0] v);
    en_wdata = v; en_wr = 1; @(negedge clk); en_wr = 0;
  endtask

  function automatic logic [3:0] exp_stat(input logic [7:0] d, input bit x, input bit stp);
    logic pe = par_en && !mp_mode && ((^d ^ x) != par_odd);
    return {mp_mode && x, !stp && d == 0, !stp, pe};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q [4];
    repeat (3) @(negedge clk);
    chk(!rd_valid && !ovr && !rx_on && !tx_on, "R1 reset", {rd_valid, ovr, rx_on, tx_on}, 0);
    rst_n = 1;
    @(negedge clk);
    // R12 disabled receiver ignores a frame
    send(8'h5A, 0, 0, 1);
    chk(!rd_valid, "R12 off", rd_valid, 0);
    wr_en(2'b11);
    chk(rx_on && tx_on, "R1 enable write", {rx_on, tx_on}, 3);

    // R7 pop on empty ignored
    do_pop();
    chk(!rd_valid, "R7 empty pop", rd_valid, 0);

    // R2 R4 R5 R6 sweep over every data value
    for (int d = 0; d < 256; d++) begin
      logic x, stp;
      case (d % 4)
        0: begin par_en = 0; mp_mode = 0; end
        1: begin par_en = 1; par_odd = 0; mp_mode = 0; end
        2: begin par_en = 1; par_odd = 1; mp_mode = 0; end
        default: begin par_en = 0; mp_mode = 1; end
      endcase
      x = d[2];
      stp = (d % 16 != 5);
      send(8'(d), par_en || mp_mode, x, stp);
      chk(rd_valid && rd_data == 8'(d), "R2 data", rd_data, d);
      chk(rd_stat == exp_stat(8'(d), x, stp), "R4 R5 R6 status", rd_stat, exp_stat(8'(d), x, stp));
      do_pop();
    end
    par_en = 0; mp_mode = 0;

    // R5 break
    send(8'h00, 0, 0, 0);
    chk(rd_stat == 4'b0110, "R5 break", rd_stat, 4'b0110);
    do_pop();

    // R3 false start: low for a quarter bit
    hold(0, 4); hold(1, 64);
    chk(!rd_valid, "R3 false start", rd_valid, 0);

    // R2 slower divider
    baud_div = 2;
    for (int k = 0; k < 6; k++) begin
      send(8'(8'h31 * k + 8'h0F), 0, 0, 1);
      chk(rd_valid && rd_data == 8'(8'h31 * k + 8'h0F), "R2 div2", rd_data, 8'h31 * k + 8'h0F);
      do_pop();
    end
    baud_div = 0;

    // R7 R8 order and overrun
    for (int k = 0; k < 5; k++) send(8'(8'hA0 + k), 0, 0, 1);
    chk(ovr, "R8 ovr set", ovr, 1);
    for (int k = 0; k < 4; k++) begin
      chk(rd_valid && rd_data == 8'(8'hA0 + k), "R7 R8 order", rd_data, 8'hA0 + k);
      do_pop();
    end
    chk(!rd_valid, "R7 drained", rd_valid, 0);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(!ovr, "R8 ovr clear", ovr, 0);

    // R11 dcd without auto
    send(8'h3C, 0, 0, 0);
    dcd = 1; repeat (4) @(negedge clk);
    chk(rd_valid && rd_stat == 4'b0010 && rx_on, "R11 dcd ignored", {rd_valid, rd_stat, rx_on}, 6'b100101);
    dcd = 0;

    // R9 io_stop
    for (int k = 0; k < 4; k++) q[k] = 8'(k);
    send(q[1], 0, 0, 1);
    io_stop = 1; en_wdata = 2'b11; en_wr = 1; @(negedge clk); en_wr = 0; io_stop = 0;
    chk(!rd_valid && !ovr && !rx_on && !tx_on, "R9 io stop", {rd_valid, ovr, rx_on, tx_on}, 0);
    wr_en(2'b01);
    send(8'h81, 0, 0, 1);
    chk(rd_valid && rd_data == 8'h81 && rd_stat == 0, "R9 no stale status", rd_stat, 0);

    // R10 carrier with auto
    dcd_auto = 1; dcd = 1; @(negedge clk);
    chk(!rd_valid && !rx_on, "R10 flush", {rd_valid, rx_on}, 0);
    wr_en(2'b11);
    chk(!rx_on && !tx_on, "R10 enables held", {rx_on, tx_on}, 0);
    dcd = 0;
    wr_en(2'b01);
    send(8'hE7, 0, 0, 1);
    chk(rd_valid && rd_data == 8'hE7, "R10 resume", rd_data, 8'hE7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule